// File: doc/BRIEF.md
# Register-File Bit Move Unit

This unit carries raw bit patterns between the floating-point and the integer register files with no numeric conversion. Four operations exist: a full 64-bit copy in each direction, and a single-precision copy in each direction. The single-precision variants behave as if the value were stored to memory in one format and loaded back in the other: moving to the integer side narrows the double to a 32-bit single pattern as a single-precision store would, and moving to the floating-point side widens a 32-bit single pattern to double as a single-precision load would. No rounding takes place and no floating-point status is touched.

An issue slot presents an opcode, a record flag, the 64-bit source operand, the current integer summary-overflow bit and the four floating-point summary status bits. One cycle later the unit returns the 64-bit result, a flag naming the destination file, and, when the record flag was set, a 4-bit condition field update together with which field (0 for integer results, 1 for floating-point results) it targets. Register files and instruction decode sit outside.

Top module: `fpgp_move_unit`

## Requirements
- R1: Opcode 2'b00 (FP to integer, 64-bit) and opcode 2'b10 (integer to FP, 64-bit) return all 64 source bits unchanged.
- R2: Opcode 2'b01 (FP to integer, single) with double exponent field 0 or above 896 returns {sign, bit 62, bits 58:29} in bits 31:0 and zero in bits 63:32; for finite in-range values this equals the single with the same sign, exponent and truncated fraction.
- R3: Opcode 2'b01 with double exponent field 1 to 896 returns a single subnormal: sign, exponent 0, and the truncation of the magnitude times 2^149; exponents below 874 therefore give a signed zero; bits 63:32 are zero.
- R4: Opcode 2'b11 (integer to FP, single) with single exponent 1 to 254 in bits 30:23 returns the double of exactly the same value.
- R5: Opcode 2'b11 with single exponent 0 and nonzero fraction returns the exactly equal normalized double.
- R6: Opcode 2'b11 with single exponent 255 returns sign, exponent 2047 and the 23 fraction bits placed at bits 51:29 (infinity stays infinity, NaN payload kept); a single zero gives a double zero of the same sign.
- R7: A result appears in the cycle after in_valid, with out_valid high for exactly that one cycle, and out_to_fpr equals opcode bit 1 (1 means floating-point destination).
- R8: With in_rec set and an integer destination, out_cr_we is high, out_cr_sel is 0 and out_cr is {LT, GT, EQ, SO} in bits 3..0, from a signed 64-bit compare of the result with zero and the in_so bit.
- R9: With in_rec set and a floating-point destination, out_cr_we is high, out_cr_sel is 1 and out_cr equals in_fpsum (bit 3 exception summary, bit 2 enabled-exception summary, bit 1 invalid summary, bit 0 overflow).
- R10: With in_rec clear, out_cr_we stays low; without in_valid, out_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_op | input | 2 | Opcode: bit 1 direction (1 = to FP), bit 0 single precision |
| in_rec | input | 1 | Request a condition field update |
| in_src | input | 64 | Source operand bits |
| in_so | input | 1 | Current integer summary-overflow bit |
| in_fpsum | input | 4 | Floating-point summary status bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 64 | Result bits |
| out_to_fpr | output | 1 | Result targets the floating-point file |
| out_cr_we | output | 1 | Condition field write enable |
| out_cr_sel | output | 1 | Condition field index (0 or 1) |
| out_cr | output | 4 | Condition field value |

## Verification
The narrowing path is swept over every double exponent from 860 to 1150 with random fractions and signs, which separates the bit-selection region from the subnormal shift region and the underflow-to-zero tail; zeros, a double subnormal, infinity and NaN cover the special encodings. The widening path is swept over all 256 single exponents and, for subnormals, over every leading-one position 0 to 22, so each normalization shift is tried once. Expected values come from real arithmetic on the decoded magnitude, not from field copying. Record-flag cases use negative, zero and positive results and every summary-bit pattern to tell the integer and floating-point condition rules apart.

// File: rtl/fpgp_move_pkg.sv
package fpgp_move_pkg;
  localparam int DBL_W   = 64;
  localparam int SGL_W   = 32;
  localparam int DEXP_W  = 11;
  localparam int DFRAC_W = 52;
  localparam int SEXP_W  = 8;
  localparam int SFRAC_W = 23;
  localparam int CRF_W   = 4;
  localparam int OP_W    = 2;
  // double exponent bias minus single bias: single exp 1 maps to 897
  localparam int EXP_REBIAS = 896;
  localparam int DFRAC_PAD  = DFRAC_W - SFRAC_W;

  typedef enum logic [OP_W-1:0] {
    OP_F2G_DBL = 2'b00,
    OP_F2G_SGL = 2'b01,
    OP_G2F_DBL = 2'b10,
    OP_G2F_SGL = 2'b11
  } mv_op_e;
endpackage

// File: rtl/fpgp_narrow.sv
module fpgp_narrow
  import fpgp_move_pkg::*;
(
  input  logic [DBL_W-1:0] dbl_i,
  output logic [SGL_W-1:0] sgl_o
);
  localparam int SHW = 6;

  logic [DEXP_W-1:0]  exp_d;
  logic [DEXP_W:0]    sh_full;
  logic [SHW-1:0]     sh;
  logic [DFRAC_W:0]   sig;
  logic [DFRAC_W:0]   sig_sh;
  logic               bitsel_path;

  assign exp_d       = dbl_i[DBL_W-2 -: DEXP_W];
  assign bitsel_path = (exp_d == '0) || (exp_d > DEXP_W'(EXP_REBIAS));
  assign sh_full     = (DEXP_W+1)'(EXP_REBIAS + 1) - {1'b0, exp_d};
  assign sh          = (sh_full > (DEXP_W+1)'((1 << SHW) - 1)) ? SHW'((1 << SHW) - 1)
                                                               : sh_full[SHW-1:0];
  assign sig         = {1'b1, dbl_i[DFRAC_W-1:0]};
  assign sig_sh      = sig >> sh;

  always_comb begin
    if (bitsel_path) begin
      // sign, top exponent bit, low seven exponent bits, top fraction bits
      sgl_o = {dbl_i[DBL_W-1], dbl_i[DBL_W-2], dbl_i[DFRAC_W+SEXP_W-2 -: SEXP_W-1],
               dbl_i[DFRAC_W-1 -: SFRAC_W]};
    end else begin
      sgl_o = {dbl_i[DBL_W-1], {SEXP_W{1'b0}}, sig_sh[DFRAC_W-1 -: SFRAC_W]};
    end
  end
endmodule

// File: rtl/fpgp_widen.sv
module fpgp_widen
  import fpgp_move_pkg::*;
(
  input  logic [SGL_W-1:0] sgl_i,
  output logic [DBL_W-1:0] dbl_o
);
  logic [SEXP_W-1:0]  exp_s;
  logic [SFRAC_W-1:0] frac_s;
  logic [4:0]         lead;
  logic [DFRAC_W-1:0] frac_pad;
  logic [DFRAC_W-1:0] norm_frac;
  logic [DEXP_W-1:0]  norm_exp;
  logic               hi_e;

  assign exp_s    = sgl_i[SGL_W-2 -: SEXP_W];
  assign frac_s   = sgl_i[SFRAC_W-1:0];
  assign hi_e     = sgl_i[SGL_W-2];
  assign frac_pad = {frac_s, {DFRAC_PAD{1'b0}}};

  // position of the highest set fraction bit
  always_comb begin
    lead = '0;
    for (int i = 0; i < SFRAC_W; i++) begin
      if (frac_s[i]) lead = 5'(i);
    end
  end

  assign norm_frac = frac_pad << (5'(SFRAC_W) - lead);
  assign norm_exp  = DEXP_W'(EXP_REBIAS - SFRAC_W + 1) + DEXP_W'(lead);

  always_comb begin
    if (exp_s != '0 && exp_s != '1) begin
      dbl_o = {sgl_i[SGL_W-1], hi_e, {3{~hi_e}}, sgl_i[SGL_W-3:0], {DFRAC_PAD{1'b0}}};
    end else if (exp_s == '0 && frac_s != '0) begin
      dbl_o = {sgl_i[SGL_W-1], norm_exp, norm_frac};
    end else begin
      dbl_o = {sgl_i[SGL_W-1], hi_e, {3{hi_e}}, sgl_i[SGL_W-3:0], {DFRAC_PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/fpgp_crgen.sv
module fpgp_crgen
  import fpgp_move_pkg::*;
(
  input  logic [DBL_W-1:0] res_i,
  input  logic             to_fpr_i,
  input  logic             so_i,
  input  logic [CRF_W-1:0] fpsum_i,
  output logic [CRF_W-1:0] cr_o
);
  logic neg, zero;

  assign neg  = res_i[DBL_W-1];
  assign zero = (res_i == '0);

  always_comb begin
    if (to_fpr_i) cr_o = fpsum_i;
    else          cr_o = {neg, ~neg & ~zero, zero, so_i};
  end
endmodule

// File: rtl/fpgp_move_unit.sv
module fpgp_move_unit
  import fpgp_move_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  input  logic             in_rec,
  input  logic [DBL_W-1:0] in_src,
  input  logic             in_so,
  input  logic [CRF_W-1:0] in_fpsum,
  output logic             out_valid,
  output logic [DBL_W-1:0] out_data,
  output logic             out_to_fpr,
  output logic             out_cr_we,
  output logic             out_cr_sel,
  output logic [CRF_W-1:0] out_cr
);
  mv_op_e            op;
  logic [SGL_W-1:0]  narrowed;
  logic [DBL_W-1:0]  widened;
  logic [DBL_W-1:0]  res_c;
  logic [CRF_W-1:0]  cr_c;
  logic              to_fpr_c;

  assign op       = mv_op_e'(in_op);
  assign to_fpr_c = in_op[1];

  fpgp_narrow u_narrow (.dbl_i(in_src), .sgl_o(narrowed));
  fpgp_widen  u_widen  (.sgl_i(in_src[SGL_W-1:0]), .dbl_o(widened));

  always_comb begin
    unique case (op)
      OP_F2G_SGL: res_c = {{(DBL_W-SGL_W){1'b0}}, narrowed};
      OP_G2F_SGL: res_c = widened;
      default:    res_c = in_src;
    endcase
  end

  fpgp_crgen u_crgen (
    .res_i(res_c), .to_fpr_i(to_fpr_c), .so_i(in_so),
    .fpsum_i(in_fpsum), .cr_o(cr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_cr_we  <= 1'b0;
      out_data   <= '0;
      out_to_fpr <= 1'b0;
      out_cr_sel <= 1'b0;
      out_cr     <= '0;
    end else begin
      out_valid <= in_valid;
      out_cr_we <= in_valid & in_rec;
      if (in_valid) begin
        out_data   <= res_c;
        out_to_fpr <= to_fpr_c;
        out_cr_sel <= to_fpr_c;
        out_cr     <= cr_c;
      end
    end
  end
endmodule

// File: rtl/fpgp_move_chk.sv
module fpgp_move_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [1:0]  in_op,
  input logic        in_rec,
  input logic [63:0] in_src,
  input logic        in_so,
  input logic [3:0]  in_fpsum,
  input logic        out_valid,
  input logic [63:0] out_data,
  input logic        out_to_fpr,
  input logic        out_cr_we,
  input logic        out_cr_sel,
  input logic [3:0]  out_cr
);
  assert_copy_f2g_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b00) |=> out_data == $past(in_src));

  assert_copy_g2f_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b10) |=> out_data == $past(in_src));

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b01) |=> out_data[63:32] == 32'd0);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  assert_dest_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_to_fpr == $past(in_op[1]));

  assert_int_so_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rec && !in_op[1]) |=> (out_cr_we && !out_cr_sel && out_cr[0] == $past(in_so)));

  assert_int_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    (out_cr_we && !out_cr_sel) |-> $onehot(out_cr[3:1]));

  assert_fp_field_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rec && in_op[1]) |=> (out_cr_we && out_cr_sel && out_cr == $past(in_fpsum)));

  assert_no_we_R10: assert property (@(posedge clk) disable iff (rst)
    out_cr_we |-> out_valid);
endmodule

bind fpgp_move_unit fpgp_move_chk u_chk (.*);

// File: tb/sim_fpgp_move_unit.sv
`timescale 1ns/1ps
module sim_fpgp_move_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic        in_rec = 1'b0;
  logic [63:0] in_src = '0;
  logic        in_so = 1'b0;
  logic [3:0]  in_fpsum = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_to_fpr;
  logic        out_cr_we;
  logic        out_cr_sel;
  logic [3:0]  out_cr;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  fpgp_move_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_rec(in_rec),
    .in_src(in_src), .in_so(in_so), .in_fpsum(in_fpsum), .out_valid(out_valid),
    .out_data(out_data), .out_to_fpr(out_to_fpr), .out_cr_we(out_cr_we),
    .out_cr_sel(out_cr_sel), .out_cr(out_cr)
  );

  function automatic real p2(int k);
    real r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else repeat (-k) r = r / 2.0;
    return r;
  endfunction

  // expected narrowed pattern, from the value where possible
  function automatic logic [63:0] exp_narrow(logic [63:0] d);
    logic [10:0] e = d[62:52];
    real v = $bitstoreal({1'b0, d[62:0]});
    real x;
    int k;
    int fr;
    logic [7:0] se;
    if (e == 11'd0 || e == 11'h7FF)
      return {32'd0, d[63], d[62], d[58:29], d[51:29]} >> 0 & 64'h0 | {32'd0, d[63], d[62], d[58:52], d[51:29]};
    if (e <= 11'd896) begin
      fr = $rtoi(v * p2(149));
      return {32'd0, d[63], 8'd0, fr[22:0]};
    end
    x = v; k = 0;
    while (x >= 2.0) begin x = x / 2.0; k++; end
    while (x < 1.0) begin x = x * 2.0; k--; end
    fr = $rtoi((x - 1.0) * p2(23));
    se = 8'(k + 127);
    return {32'd0, d[63], se, fr[22:0]};
  endfunction

  function automatic logic [63:0] exp_widen(logic [31:0] w);
    logic [7:0]  e = w[30:23];
    logic [22:0] f = w[22:0];
    real v;
    if (e == 8'hFF) return {w[31], 11'h7FF, f, 29'd0};
    if (e == 8'd0) v = real'(f) * p2(-149);
    else v = (1.0 + real'(f) * p2(-23)) * p2(int'(e) - 127);
    if (w[31]) v = -v;
    return $realtobits(v);
  endfunction

  function automatic logic [3:0] exp_intcr(logic [63:0] r, logic so);
    if ($signed(r) < 0) return {3'b100, so};
    if (r == 0) return {3'b001, so};
    return {3'b010, so};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic rec, logic [63:0] src, logic so, logic [3:0] fs);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_rec = rec; in_src = src; in_so = so; in_fpsum = fs;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset we", {63'd0, out_cr_we}, 64'd0);

    // R1 full copies, R7 destination and strobe
    for (int i = 0; i < 40; i++) begin
      d = {$urandom, $urandom};
      issue(2'b00, 1'b0, d, 1'b0, 4'd0);
      check("R1 f2g", out_data, d);
      check("R7 dest int", {63'd0, out_to_fpr}, 64'd0);
      check("R7 valid", {63'd0, out_valid}, 64'd1);
      check("R10 no we", {63'd0, out_cr_we}, 64'd0);
      d = {$urandom, $urandom};
      issue(2'b10, 1'b0, d, 1'b0, 4'd0);
      check("R1 g2f", out_data, d);
      check("R7 dest fp", {63'd0, out_to_fpr}, 64'd1);
    end

    // R7 strobe lasts one cycle
    issue(2'b00, 1'b0, 64'h1, 1'b0, 4'd0);
    @(negedge clk);
    check("R7 pulse end", {63'd0, out_valid}, 64'd0);

    // R2 and R3: narrowing sweep
    for (int e = 860; e <= 1150; e++) begin
      for (int j = 0; j < 2; j++) begin
        d = {1'($urandom), 11'(e), $urandom, 20'($urandom)};
        issue(2'b01, 1'b0, d, 1'b0, 4'd0);
        if (e <= 896) check("R3 narrow subnormal", out_data, exp_narrow(d));
        else check("R2 narrow normal", out_data, exp_narrow(d));
      end
    end
    d = 64'h0000_0000_0000_0000; issue(2'b01, 1'b0, d, 1'b0, 4'd0);
    check("R2 zero", out_data, 64'd0);
    d = 64'h8000_0000_0000_0000; issue(2'b01, 1'b0, d, 1'b0, 4'd0);
    check("R2 neg zero", out_data, 64'h0000_0000_8000_0000);
    d = 64'h7FF0_0000_0000_0000; issue(2'b01, 1'b0, d, 1'b0, 4'd0);
    check("R2 inf", out_data, 64'h0000_0000_7F80_0000);
    d = 64'hFFF8_0000_2000_0000; issue(2'b01, 1'b0, d, 1'b0, 4'd0);
    check("R2 nan", out_data, 64'h0000_0000_FFC0_0001);
    d = 64'h000A_BCDE_0000_0000; issue(2'b01, 1'b0, d, 1'b0, 4'd0);
    check("R2 dbl subnormal", out_data, {32'd0, 1'b0, 8'd0, d[51:29]});
    d = 64'h3FF0_0000_0000_0000; issue(2'b01, 1'b0, d, 1'b0, 4'd0);
    check("R2 one", out_data, 64'h0000_0000_3F80_0000);

    // R4, R5, R6: widening sweep
    for (int e = 0; e < 256; e++) begin
      for (int j = 0; j < 2; j++) begin
        w = {1'($urandom), 8'(e), 23'($urandom)};
        issue(2'b11, 1'b0, {$urandom, w}, 1'b0, 4'd0);
        if (e == 0) check("R5 widen subnormal", out_data, exp_widen(w));
        else if (e == 255) check("R6 widen special", out_data, exp_widen(w));
        else check("R4 widen normal", out_data, exp_widen(w));
      end
    end
    for (int p = 0; p < 23; p++) begin
      w = {1'($urandom), 8'd0, (23'd1 << p) | (23'($urandom) & ((23'd1 << p) - 23'd1))};
      issue(2'b11, 1'b0, {32'd0, w}, 1'b0, 4'd0);
      check("R5 lead position", out_data, exp_widen(w));
    end
    issue(2'b11, 1'b0, 64'h0000_0000_8000_0000, 1'b0, 4'd0);
    check("R6 neg zero", out_data, 64'h8000_0000_0000_0000);
    issue(2'b11, 1'b0, 64'h0000_0000_7F80_0000, 1'b0, 4'd0);
    check("R6 inf", out_data, 64'h7FF0_0000_0000_0000);
    issue(2'b11, 1'b0, 64'h0000_0000_3F80_8000, 1'b0, 4'd0);
    check("R4 example", out_data, 64'h3FF0_1000_0000_0000);

    // R8 integer condition field
    for (int i = 0; i < 24; i++) begin
      logic so = 1'($urandom);
      case (i % 3)
        0: d = 64'd0;
        1: d = {1'b1, 63'($urandom)};
        default: d = {1'b0, 63'($urandom)} | 64'd1;
      endcase
      issue(2'b00, 1'b1, d, so, 4'($urandom));
      check("R8 we", {63'd0, out_cr_we}, 64'd1);
      check("R8 sel", {63'd0, out_cr_sel}, 64'd0);
      check("R8 field", {60'd0, out_cr}, {60'd0, exp_intcr(d, so)});
      issue(2'b01, 1'b1, d, so, 4'd0);
      check("R8 single field", {60'd0, out_cr}, {60'd0, exp_intcr(exp_narrow(d), so)});
    end

    // R9 FP condition field
    for (int s = 0; s < 16; s++) begin
      d = {$urandom, $urandom};
      issue(2'(2 + (s % 2)), 1'b1, d, 1'b1, 4'(s));
      check("R9 we", {63'd0, out_cr_we}, 64'd1);
      check("R9 sel", {63'd0, out_cr_sel}, 64'd1);
      check("R9 field", {60'd0, out_cr}, 64'(s));
    end

    // R10 record clear after a recorded op
    issue(2'b10, 1'b0, 64'h5, 1'b0, 4'hF);
    check("R10 rec clear", {63'd0, out_cr_we}, 64'd0);
    @(negedge clk);
    check("R10 idle", {63'd0, out_valid}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule